// File: doc/BRIEF.md
# Paged Memory-Map Chip-Select Decoder

This block sits beside an 8-bit microcontroller whose bus reaches only 8K bytes. The low address byte and the data share eight lines. When the address strobe is high at a clock edge, the block stores that byte. It then joins the byte with the five upper address lines to form a 13-bit address, which it decodes into one select per device: a RAM, a ROM, two display-controller registers and an eight-register bus interface controller. No select is active unless the data strobe is high.

Output port pins of the processor extend the address space. Two page bits choose one 4K page of a 16K ROM, and one page bit chooses one 1K half of a 2K RAM. The block registers these bits on every clock and drives them out as the high address bits of the selected memory. Because of this paging, several physical locations share the same processor address.

Top module: `pagedec_top`

## Requirements
- R1: When `as_i` is high at a rising clock edge, the low address byte `ad_i` is captured. While `as_i` is low, a change on `ad_i` does not alter any output.
- R2: Every select is low, and every page and register output is zero, while `ds_i` is low or `rst_n` is low.
- R3: Addresses 0x0000 to 0x03FF select the RAM. `ram_a_hi_o` (RAM address bit 10) then equals the registered RAM page bit.
- R4: Addresses 0x0800 to 0x0FFF select the ROM with `rom_a_hi_o` (ROM address bits 13:12) equal to 0, whatever the page bits are.
- R5: Addresses 0x1000 to 0x1FFF select the ROM with `rom_a_hi_o` equal to the registered two-bit ROM page.
- R6: Exactly address 0x040A raises `disp_sel_o[0]`, and exactly 0x0412 raises `disp_sel_o[1]`. Their neighbours raise neither.
- R7: Addresses 0x0418 to 0x041F raise `bic_sel_o`, with `bic_reg_o` equal to address bits 2:0.
- R8: Every other address in 0x0400 to 0x07FF raises no select. At most one select is high in any cycle.
- R9: A page input takes effect one rising edge after it is presented. The page outputs of a memory that is not selected read zero.
- R10: Reset clears the stored low byte and the page register. After release with `ds_i` high, upper lines at zero and no new capture, the RAM is selected with page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_i | input | 1 | Address strobe, captures `ad_i` at the clock edge |
| ds_i | input | 1 | Data strobe, qualifies every select |
| ad_i | input | 8 | Multiplexed low address / data byte |
| a_hi_i | input | 5 | Upper address lines, bits 12:8 |
| rom_page_i | input | 2 | ROM page bits from port pins |
| ram_page_i | input | 1 | RAM page bit from a port pin |
| ram_sel_o | output | 1 | RAM select |
| rom_sel_o | output | 1 | ROM select |
| disp_sel_o | output | 2 | Display-controller register selects |
| bic_sel_o | output | 1 | Bus interface controller select |
| bic_reg_o | output | 3 | Register index within the bus interface controller |
| rom_a_hi_o | output | 2 | ROM address bits 13:12 |
| ram_a_hi_o | output | 1 | RAM address bit 10 |

## Verification
The bench aims at the edges of every region: 0x03FF and 0x0400, 0x07FF and 0x0800, 0x0FFF and 0x1000, both sides of each display address, and 0x0417 and 0x0420. A decoder with an off-by-one limit would select the wrong device or none at these points. It also sets nonzero page bits on fixed-ROM accesses, since a design that paged the whole ROM would leak them into address bits 13:12. The bench changes the muxed byte during the data phase to catch a latch that is transparent, and changes the page bits between edges to catch page logic that is unregistered. Random addresses and pages, compared against a separately written map, cover the rest.

// File: rtl/pagedec_pkg.sv
package pagedec_pkg;
  localparam int ADDR_W    = 13;
  localparam int LOW_W     = 8;
  localparam int HI_W      = ADDR_W - LOW_W;
  localparam int ROM_PG_W  = 2;
  localparam int RAM_PG_W  = 1;
  localparam int DISP_N    = 2;
  localparam int BIC_W     = 3;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t RAM_LAST       = addr_t'(13'h03FF);
  localparam addr_t ROM_FIX_BASE   = addr_t'(13'h0800);
  localparam addr_t ROM_PAGED_BASE = addr_t'(13'h1000);
  localparam addr_t DISP0_ADDR     = addr_t'(13'h040A);
  localparam addr_t DISP1_ADDR     = addr_t'(13'h0412);
  localparam addr_t BIC_BASE       = addr_t'(13'h0418);

  function automatic logic in_ram(addr_t a);
    return a <= RAM_LAST;
  endfunction

  function automatic logic in_rom_fixed(addr_t a);
    return (a >= ROM_FIX_BASE) && (a < ROM_PAGED_BASE);
  endfunction

  function automatic logic in_rom_paged(addr_t a);
    return a >= ROM_PAGED_BASE;
  endfunction

  function automatic addr_t disp_addr(int idx);
    return (idx == 0) ? DISP0_ADDR : DISP1_ADDR;
  endfunction

  function automatic logic in_bic(addr_t a);
    return a[ADDR_W-1:BIC_W] == BIC_BASE[ADDR_W-1:BIC_W];
  endfunction
endpackage

// File: rtl/pagedec_alatch.sv
module pagedec_alatch
  import pagedec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [LOW_W-1:0] bus_in,
  output logic [LOW_W-1:0] low_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_q <= '0;
    else if (strobe) low_q <= bus_in;
  end
endmodule

// File: rtl/pagedec_pagereg.sv
module pagedec_pagereg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pg_in,
  output logic [W-1:0] pg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= '0;
    else        pg_q <= pg_in;
  end
endmodule

// File: rtl/pagedec_decode.sv
module pagedec_decode
  import pagedec_pkg::*;
(
  input  addr_t               addr,
  input  logic                en,
  input  logic [ROM_PG_W-1:0] rom_pg,
  input  logic [RAM_PG_W-1:0] ram_pg,
  output logic                ram_sel,
  output logic                rom_sel,
  output logic [DISP_N-1:0]   disp_sel,
  output logic                bic_sel,
  output logic [BIC_W-1:0]    bic_reg,
  output logic [ROM_PG_W-1:0] rom_a_hi,
  output logic [RAM_PG_W-1:0] ram_a_hi
);
  logic              ram_hit, rom_fix_hit, rom_pg_hit, bic_hit;
  logic [DISP_N-1:0] disp_hit;

  assign ram_hit     = in_ram(addr);
  assign rom_fix_hit = in_rom_fixed(addr);
  assign rom_pg_hit  = in_rom_paged(addr);
  assign bic_hit     = in_bic(addr);

  for (genvar i = 0; i < DISP_N; i++) begin : g_disp
    assign disp_hit[i] = (addr == disp_addr(i));
    assign disp_sel[i] = en & disp_hit[i];
  end

  always_comb begin
    ram_sel  = en & ram_hit;
    rom_sel  = en & (rom_fix_hit | rom_pg_hit);
    bic_sel  = en & bic_hit;
    bic_reg  = bic_sel ? addr[BIC_W-1:0] : '0;
    rom_a_hi = (en & rom_pg_hit) ? rom_pg : '0;
    ram_a_hi = ram_sel ? ram_pg : '0;
  end
endmodule

// File: rtl/pagedec_top.sv
module pagedec_top
  import pagedec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                as_i,
  input  logic                ds_i,
  input  logic [LOW_W-1:0]    ad_i,
  input  logic [HI_W-1:0]     a_hi_i,
  input  logic [ROM_PG_W-1:0] rom_page_i,
  input  logic [RAM_PG_W-1:0] ram_page_i,
  output logic                ram_sel_o,
  output logic                rom_sel_o,
  output logic [DISP_N-1:0]   disp_sel_o,
  output logic                bic_sel_o,
  output logic [BIC_W-1:0]    bic_reg_o,
  output logic [ROM_PG_W-1:0] rom_a_hi_o,
  output logic [RAM_PG_W-1:0] ram_a_hi_o
);
  localparam int PG_W = ROM_PG_W + RAM_PG_W;

  logic [LOW_W-1:0]    lat_q;
  logic [PG_W-1:0]     pg_q;
  logic [ROM_PG_W-1:0] rom_pg_q;
  logic [RAM_PG_W-1:0] ram_pg_q;
  addr_t               full_addr;
  logic                bus_en;

  pagedec_alatch u_alatch (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (as_i),
    .bus_in (ad_i),
    .low_q  (lat_q)
  );

  pagedec_pagereg #(.W(PG_W)) u_pagereg (
    .clk   (clk),
    .rst_n (rst_n),
    .pg_in ({rom_page_i, ram_page_i}),
    .pg_q  (pg_q)
  );

  assign rom_pg_q  = pg_q[PG_W-1:RAM_PG_W];
  assign ram_pg_q  = pg_q[RAM_PG_W-1:0];
  assign full_addr = {a_hi_i, lat_q};
  assign bus_en    = ds_i & rst_n;

  pagedec_decode u_decode (
    .addr     (full_addr),
    .en       (bus_en),
    .rom_pg   (rom_pg_q),
    .ram_pg   (ram_pg_q),
    .ram_sel  (ram_sel_o),
    .rom_sel  (rom_sel_o),
    .disp_sel (disp_sel_o),
    .bic_sel  (bic_sel_o),
    .bic_reg  (bic_reg_o),
    .rom_a_hi (rom_a_hi_o),
    .ram_a_hi (ram_a_hi_o)
  );
endmodule

// File: rtl/pagedec_chk.sv
module pagedec_chk
  import pagedec_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                as_i,
  input logic                ds_i,
  input logic [LOW_W-1:0]    ad_i,
  input logic [HI_W-1:0]     a_hi_i,
  input logic [ROM_PG_W-1:0] rom_page_i,
  input logic [RAM_PG_W-1:0] ram_page_i,
  input logic [LOW_W-1:0]    lat_q,
  input logic                ram_sel_o,
  input logic                rom_sel_o,
  input logic [DISP_N-1:0]   disp_sel_o,
  input logic                bic_sel_o,
  input logic [ROM_PG_W-1:0] rom_a_hi_o,
  input logic [RAM_PG_W-1:0] ram_a_hi_o
);
  logic [DISP_N+2:0] sel_vec;
  assign sel_vec = {ram_sel_o, rom_sel_o, disp_sel_o, bic_sel_o};

  p_latch_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    as_i |=> lat_q == $past(ad_i));
  p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !as_i |=> $stable(lat_q));
  p_ds_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_i |-> sel_vec == '0);
  p_ram_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel_o && $past(rst_n)) |-> ram_a_hi_o == $past(ram_page_i));
  p_rom_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel_o && a_hi_i[HI_W-1:HI_W-2] == 2'b01) |-> rom_a_hi_o == '0);
  p_rom_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel_o && a_hi_i[HI_W-1] && $past(rst_n)) |-> rom_a_hi_o == $past(rom_page_i));
  p_one_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));
  p_rom_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_sel_o |-> rom_a_hi_o == '0);
  p_ram_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel_o |-> ram_a_hi_o == '0);

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r2: assert (sel_vec == '0);
    end
  end
endmodule

bind pagedec_top pagedec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .as_i       (as_i),
  .ds_i       (ds_i),
  .ad_i       (ad_i),
  .a_hi_i     (a_hi_i),
  .rom_page_i (rom_page_i),
  .ram_page_i (ram_page_i),
  .lat_q      (lat_q),
  .ram_sel_o  (ram_sel_o),
  .rom_sel_o  (rom_sel_o),
  .disp_sel_o (disp_sel_o),
  .bic_sel_o  (bic_sel_o),
  .rom_a_hi_o (rom_a_hi_o),
  .ram_a_hi_o (ram_a_hi_o)
);

// File: tb/tb_pagedec_top.sv
`timescale 1ns/1ps
module tb_pagedec_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       as_i = 1'b0, ds_i = 1'b0;
  logic [7:0] ad_i = 8'h00;
  logic [4:0] a_hi_i = 5'h00;
  logic [1:0] rom_page_i = 2'b00;
  logic [0:0] ram_page_i = 1'b0;
  logic       ram_sel_o, rom_sel_o, bic_sel_o;
  logic [1:0] disp_sel_o, rom_a_hi_o;
  logic [2:0] bic_reg_o;
  logic [0:0] ram_a_hi_o;

  int  n_checks = 0, n_errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  pagedec_top dut (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .ds_i(ds_i), .ad_i(ad_i),
    .a_hi_i(a_hi_i), .rom_page_i(rom_page_i), .ram_page_i(ram_page_i),
    .ram_sel_o(ram_sel_o), .rom_sel_o(rom_sel_o), .disp_sel_o(disp_sel_o),
    .bic_sel_o(bic_sel_o), .bic_reg_o(bic_reg_o), .rom_a_hi_o(rom_a_hi_o),
    .ram_a_hi_o(ram_a_hi_o)
  );

  wire [10:0] act = {ram_sel_o, rom_sel_o, disp_sel_o[1], disp_sel_o[0], bic_sel_o,
                     bic_reg_o, rom_a_hi_o, ram_a_hi_o};

  // Packed as {ram, rom, disp1, disp0, bic, reg[2:0], rom_hi[1:0], ram_hi}
  function automatic logic [10:0] expv(int a, logic [1:0] rp, logic mp);
    logic r = 0, o = 0, d1 = 0, d0 = 0, b = 0, mh = 0;
    logic [2:0] br = 0;
    logic [1:0] oh = 0;
    if (a < 1024) begin r = 1; mh = mp; end
    else if (a >= 4096) begin o = 1; oh = rp; end
    else if (a >= 2048) o = 1;
    else if (a == 1034) d0 = 1;
    else if (a == 1042) d1 = 1;
    else if (a >= 1048 && a <= 1055) begin b = 1; br = 3'(a % 8); end
    return {r, o, d1, d0, b, br, oh, mh};
  endfunction

  task automatic check(string req, logic [10:0] got, logic [10:0] want);
    n_checks++;
    if (got !== want) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, want, $time);
    end
  endtask

  task automatic bus_cycle(int a, logic [1:0] rp, logic mp, string req);
    @(negedge clk);
    as_i = 1; ds_i = 0; ad_i = 8'(a); a_hi_i = 5'(a >> 8);
    rom_page_i = rp; ram_page_i = mp;
    @(posedge clk); #1;
    check("R2", act, 11'b0);
    @(negedge clk);
    as_i = 0; ds_i = 1; ad_i = 8'($urandom);
    #1 check(req, act, expv(a, rp, mp));
    @(posedge clk); #1;
    check("R1", act, expv(a, rp, mp));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    ds_i = 1;
    repeat (4) @(posedge clk);
    #1 check("R2", act, 11'b0);   // reset gates selects even with ds high
    @(negedge clk); rst_n = 1;
    #1 check("R10", act, expv(0, 2'b00, 1'b0));

    bus_cycle(16'h0000, 2'b11, 1'b1, "R3");
    bus_cycle(16'h03FF, 2'b10, 1'b0, "R3");
    bus_cycle(16'h03FF, 2'b01, 1'b1, "R3");
    bus_cycle(16'h0400, 2'b11, 1'b1, "R8");
    bus_cycle(16'h07FF, 2'b11, 1'b1, "R8");
    bus_cycle(16'h0800, 2'b11, 1'b1, "R4");
    bus_cycle(16'h0FFF, 2'b10, 1'b0, "R4");
    bus_cycle(16'h1000, 2'b01, 1'b1, "R5");
    bus_cycle(16'h1FFF, 2'b11, 1'b0, "R5");
    bus_cycle(16'h1ABC, 2'b10, 1'b1, "R5");
    bus_cycle(16'h0409, 2'b00, 1'b0, "R6");
    bus_cycle(16'h040A, 2'b00, 1'b0, "R6");
    bus_cycle(16'h040B, 2'b00, 1'b0, "R6");
    bus_cycle(16'h0411, 2'b00, 1'b0, "R6");
    bus_cycle(16'h0412, 2'b00, 1'b0, "R6");
    bus_cycle(16'h0413, 2'b00, 1'b0, "R6");
    bus_cycle(16'h0417, 2'b00, 1'b0, "R7");
    bus_cycle(16'h0418, 2'b00, 1'b0, "R7");
    bus_cycle(16'h041D, 2'b00, 1'b0, "R7");
    bus_cycle(16'h041F, 2'b00, 1'b0, "R7");
    bus_cycle(16'h0420, 2'b00, 1'b0, "R8");

    // R9: page change shows only after the next rising edge
    bus_cycle(16'h1234, 2'b10, 1'b0, "R5");
    @(negedge clk); rom_page_i = 2'b01;
    #1 check("R9", act, expv(16'h1234, 2'b10, 1'b0));
    @(posedge clk); #1 check("R9", act, expv(16'h1234, 2'b01, 1'b0));
    bus_cycle(16'h0155, 2'b00, 1'b0, "R3");
    @(negedge clk); ram_page_i = 1'b1;
    #1 check("R9", act, expv(16'h0155, 2'b00, 1'b0));
    @(posedge clk); #1 check("R9", act, expv(16'h0155, 2'b00, 1'b1));
    // R2: dropping ds in the data phase clears every select
    @(negedge clk); ds_i = 0;
    #1 check("R2", act, 11'b0);

    for (int k = 0; k < 300; k++) begin
      int a;
      a = (k % 3 == 0) ? int'(16'h0400 + ($urandom % 64)) : int'($urandom % 8192);
      bus_cycle(a, 2'($urandom), 1'($urandom), "R8");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule